// File: doc/BRIEF.md
# Extended Initiation Key Detector

This block watches byte writes to the plug-and-play address port and unlocks the device's configuration state when software writes the expected key. The key is produced by an 8-bit linear-feedback shift register that starts from a fixed seed. Each write that lands on the port is compared with the byte the register expects next. A matching byte advances the sequence. Any other byte sends the sequence back to its start.

In ordinary operation, 32 matching bytes move the device into the configuration state. When the board's switches select the software-write setting, the block needs a longer key: the same 32 bytes followed at once by a fixed extra byte. Completing that longer key also raises an override that lets memory programming proceed even when the protect bit is cleared. In the software-write setting the block also reports a fixed read-data port address for the rest of the chip to decode.

Top module: `ikey_top`

## Requirements
- R1: While rst_ni is low, and after it is released, cfg_state_o and wp_ovr_o are 0 and the key pointer is at the first byte.
- R2: With sw_mode_i = 0, the 32 key bytes written in order set cfg_state_o to 1 on the clock edge that accepts the 32nd byte. After only 31 bytes cfg_state_o is still 0.
- R3: With sw_mode_i = 1, 32 correct bytes are not enough. A 33rd write of 0x9C then sets both cfg_state_o and wp_ovr_o to 1 on the edge that accepts it.
- R4: A write that does not match the expected byte returns the pointer to the first byte. If the mismatching byte is the seed 0x6A, it counts as a correct first byte.
- R5: A write is accepted only on a clock edge where wr_i and port_hit_i are both 1. Otherwise the data byte has no effect.
- R6: rdp_addr_o is 12'h203 while sw_mode_i = 1 and 12'h000 while sw_mode_i = 0.
- R7: Unlocking with sw_mode_i = 0 leaves wp_ovr_o at 0. wp_ovr_o is never 1 while cfg_state_o is 0.
- R8: Once cfg_state_o is 1, it and wp_ovr_o hold their values until reset, whatever is written.
- R9: With sw_mode_i = 1, a 33rd byte other than 0x9C does not unlock the device and restarts the sequence, following the rule in R4.
- R10: Key byte 0 is 0x6A. Each following byte is the previous byte shifted right by one, with the new bit 7 equal to bit 0 XOR bit 1 of the previous byte (0x6A, 0xB5, 0xDA, 0xED, ...).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe |
| port_hit_i | input | 1 | The write targets the address port |
| data_i | input | 8 | Written byte |
| sw_mode_i | input | 1 | Software-write switch setting selected |
| cfg_state_o | output | 1 | Device is in the configuration state |
| wp_ovr_o | output | 1 | Write-protect override active |
| rdp_addr_o | output | 12 | Read-data port address |

## Verification
The hardest situation to reach is a restart partway through the key. It needs a prefix of correct bytes of every length, followed by a breaking byte, and then a full key. It also needs the case where the breaking byte is the seed itself, because the design must then count that byte as a first byte rather than throw it away. The bench therefore sweeps every prefix length from 0 to 31, breaks each one with a byte the register can never produce, and requires the key that follows to unlock the device. Directed runs cover a seed byte arriving mid-sequence, a wrong 33rd byte in software-write mode, and writes with only one of the two strobes high.

// File: rtl/ikey_pkg.sv
package ikey_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // new msb = b0 ^ b1, shift right
  function automatic byte_t lfsr_step(byte_t v);
    return {v[0] ^ v[1], v[BYTE_W-1:1]};
  endfunction
endpackage

// File: rtl/ikey_lfsr.sv
module ikey_lfsr
  import ikey_pkg::*;
#(
  parameter byte_t SEED = 8'h6A
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  logic  restart_i,
  input  logic  seed_hit_i,
  output byte_t exp_o
);
  localparam byte_t SECOND = lfsr_step(SEED);

  byte_t lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lfsr_q <= SEED;
    else if (restart_i) lfsr_q <= seed_hit_i ? SECOND : SEED;
    else if (adv_i)     lfsr_q <= lfsr_step(lfsr_q);
  end

  assign exp_o = lfsr_q;

  // R10: a nonzero seed never collapses to zero
  p_lfsr_nonzero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: rtl/ikey_ptr.sv
module ikey_ptr #(
  parameter int unsigned KEY_LEN = 32,
  localparam int unsigned PTR_W  = $clog2(KEY_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             restart_i,
  input  logic             seed_hit_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (restart_i) ptr_q <= seed_hit_i ? PTR_W'(1) : '0;
    else if (adv_i)     ptr_q <= ptr_q + PTR_W'(1);
  end

  assign ptr_o = ptr_q;

  p_ptr_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_W'(KEY_LEN));
endmodule

// File: rtl/ikey_unlock.sv
module ikey_unlock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic sw_mode_i,
  output logic cfg_o,
  output logic ovr_o
);
  logic cfg_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (done_i && !cfg_q) begin
      cfg_q <= 1'b1;
      ovr_q <= sw_mode_i;
    end
  end

  assign cfg_o = cfg_q;
  assign ovr_o = ovr_q;

  p_cfg_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q |=> cfg_q);
  p_ovr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q |=> $stable(ovr_q));
  p_ovr_needs_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> cfg_q);
  p_ovr_only_sw_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(sw_mode_i));
endmodule

// File: rtl/ikey_top.sv
module ikey_top
  import ikey_pkg::*;
#(
  parameter int unsigned KEY_LEN  = 32,
  parameter byte_t       SEED     = 8'h6A,
  parameter byte_t       EXT_BYTE = 8'h9C,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] RDP_ADDR = 12'h203
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              port_hit_i,
  input  logic [7:0]        data_i,
  input  logic              sw_mode_i,
  output logic              cfg_state_o,
  output logic              wp_ovr_o,
  output logic [ADDR_W-1:0] rdp_addr_o
);
  localparam int unsigned PTR_W = $clog2(KEY_LEN + 1);

  logic [PTR_W-1:0] ptr;
  byte_t lfsr_byte, exp_byte;
  logic  acc, at_ext, last_std, match, done, adv, restart, seed_hit;
  logic  cfg;

  assign acc      = wr_i && port_hit_i && !cfg;
  assign at_ext   = (ptr == PTR_W'(KEY_LEN));
  assign last_std = (ptr == PTR_W'(KEY_LEN - 1));
  assign exp_byte = at_ext ? EXT_BYTE : lfsr_byte;
  assign match    = (data_i == exp_byte);
  assign done     = acc && match && (at_ext || (last_std && !sw_mode_i));
  assign adv      = acc && match && !done;
  assign restart  = acc && !match;
  assign seed_hit = (data_i == SEED);

  ikey_lfsr #(.SEED(SEED)) i_lfsr (
    .clk_i, .rst_ni,
    .adv_i(adv), .restart_i(restart), .seed_hit_i(seed_hit),
    .exp_o(lfsr_byte)
  );

  ikey_ptr #(.KEY_LEN(KEY_LEN)) i_ptr (
    .clk_i, .rst_ni,
    .adv_i(adv), .restart_i(restart), .seed_hit_i(seed_hit),
    .ptr_o(ptr)
  );

  ikey_unlock i_unlock (
    .clk_i, .rst_ni,
    .done_i(done), .sw_mode_i,
    .cfg_o(cfg), .ovr_o(wp_ovr_o)
  );

  assign cfg_state_o = cfg;
  assign rdp_addr_o  = sw_mode_i ? RDP_ADDR : '0;

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && port_hit_i) |=> $stable(ptr));
  p_no_early_cfg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg) |-> ($past(ptr) >= PTR_W'(KEY_LEN - 1)));
  p_sw_needs_ext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cfg) && $past(sw_mode_i)) |-> $past(data_i) == EXT_BYTE);
endmodule

// File: tb/test_ikey_top.sv
module test_ikey_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, wr = 0, hit = 0, sw = 0;
  logic [7:0] data = 0;
  logic cfg, ovr;
  logic [11:0] rdp;
  int n_chk = 0, n_fail = 0;
  logic [7:0] key [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  ikey_top i_ikey_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .port_hit_i(hit), .data_i(data),
    .sw_mode_i(sw), .cfg_state_o(cfg), .wp_ovr_o(ovr), .rdp_addr_o(rdp)
  );

  function automatic logic [7:0] nxt(logic [7:0] v);
    return {v[0] ^ v[1], v[7:1]};
  endfunction

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr = 0; hit = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_byte(logic [7:0] d, logic w = 1, logic h = 1);
    @(negedge clk); wr = w; hit = h; data = d;
    @(posedge clk); #1; wr = 0; hit = 0;
  endtask

  task automatic send_key(int from, int n);
    for (int i = from; i < from + n; i++) wr_byte(key[i]);
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  initial begin
    key[0] = 8'h6A;
    for (int i = 1; i < 32; i++) key[i] = nxt(key[i-1]);

    // R1 reset state
    do_reset(); sample();
    chk("R1 cfg", cfg, 0); chk("R1 ovr", ovr, 0);
    // R6 read-data port
    chk("R6 rdp sw=0", rdp, 12'h000);
    sw = 1; #1; chk("R6 rdp sw=1", rdp, 12'h203); sw = 0;
    // R10 sanity of first few bytes
    chk("R10 byte1", key[1], 8'hB5); chk("R10 byte3", key[3], 8'hED);

    // R2 exact length
    do_reset(); send_key(0, 31); sample();
    chk("R2 after 31", cfg, 0);
    send_key(31, 1); sample();
    chk("R2 after 32", cfg, 1);
    chk("R7 no ovr outside sw", ovr, 0);
    // R8 sticky
    wr_byte(8'h00); wr_byte(8'h6A); sample();
    chk("R8 cfg held", cfg, 1); chk("R8 ovr held", ovr, 0);

    // R4 sweep: every prefix, broken by 0x00 (never produced), then full key
    for (int k = 0; k < 32; k++) begin
      do_reset(); send_key(0, k); wr_byte(8'h00); send_key(0, 31); sample();
      chk($sformatf("R4 prefix %0d pre", k), cfg, 0);
      send_key(31, 1); sample();
      chk($sformatf("R4 prefix %0d restart", k), cfg, 1);
    end

    // R4 seed as breaking byte counts as first byte
    do_reset(); send_key(0, 5); send_key(0, 32); sample();
    chk("R4 seed restarts", cfg, 1);

    // R5 half strobes ignored
    do_reset(); send_key(0, 10);
    wr_byte(8'h00, 1, 0); wr_byte(8'h00, 0, 1);
    send_key(10, 22); sample();
    chk("R5 ignored writes", cfg, 1);

    // R3 software-write mode
    do_reset(); sw = 1; send_key(0, 32); sample();
    chk("R3 32 not enough", cfg, 0);
    wr_byte(8'h9C); sample();
    chk("R3 cfg", cfg, 1); chk("R3 ovr", ovr, 1);
    chk("R7 ovr with cfg", ovr & cfg, 1);
    wr_byte(8'h11); sample(); chk("R8 ovr held sw", ovr, 1);

    // R9 wrong 33rd byte
    do_reset(); send_key(0, 32); wr_byte(8'h55); sample();
    chk("R9 wrong ext", cfg, 0);
    wr_byte(8'h9C); sample();
    chk("R9 ext alone no unlock", cfg, 0);
    send_key(0, 32); wr_byte(8'h9C); sample();
    chk("R9 retry unlock", cfg, 1);
    do_reset(); send_key(0, 32); send_key(0, 32); wr_byte(8'h9C); sample();
    chk("R9 seed as 33rd", cfg, 1);
    sw = 0;

    // R1 reset clears unlocked state
    do_reset(); sample();
    chk("R1 cfg after re-reset", cfg, 0); chk("R1 ovr after re-reset", ovr, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule